// File: doc/BRIEF.md
# Shared-Bus Ownership Switch

This block decides which of two bus masters may reach a shared test ROM and a shared scratch RAM. The two masters are a supervising processor and a processor under test. After reset the supervisor owns the bus. Once the verification input shows that the mode check has passed, the supervisor may request a handover. The block then steps through a fixed sequence: one idle cycle, a test phase in which only the processor under test reaches memory, and a second idle cycle when the test processor signals that it has finished. After that, ownership is back with the supervisor, which can read the results the test left in RAM.

Each master port is a request channel with `valid` and `ready`. A transfer completes in any cycle in which both are high. `ready` is low only during the two idle cycles of the handover sequence, so a master holds its request until the sequence moves on. Both memories return read data in the same cycle. Bit `ADDR_W-1` of the address selects the region: 0 is the ROM and 1 is the RAM. The remaining bits index a word.

A master that does not own the bus still sees `ready` high. Its accesses have no effect, and its reads return zero. A write aimed at the ROM is never forwarded, and it latches a violation flag that only reset clears.

Top module: `bus_owner_switch`

## Requirements
- R1: After reset the supervisor owns the bus, `test_active` is 0 and `rom_wr_viol` is 0.
- R2: While `verify_done` is low, a `handover_req` has no effect: the supervisor keeps ownership and test-master reads return 0.
- R3: A `handover_req` sampled with `verify_done` high in the supervisor phase is followed by exactly one idle cycle, and `test_active` is 1 from the second clock edge after the request.
- R4: In each idle cycle of the sequence, both masters see `ready` low and neither `rom_en` nor `ram_en` is asserted.
- R5: In the test phase, the test master reads the ROM (address bit `ADDR_W-1` = 0) and reads and writes the RAM (bit = 1). Its read data equals the addressed memory word.
- R6: The master that does not own the bus sees `ready` 1 and read data 0, and its access asserts no memory enable.
- R7: An owner write to the ROM region is dropped, with `rom_en` staying low. `rom_wr_viol` goes to 1 at the next edge and stays 1 until reset.
- R8: A `test_done` in the test phase is followed by one idle cycle, after which the supervisor owns the bus and reads the RAM contents written during the test.
- R9: `test_done` outside the test phase, and `handover_req` outside the supervisor phase, have no effect.
- R10: In the supervisor phase, the supervisor reads the ROM and reads and writes the RAM.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| verify_done | input | 1 | Level: mode check has passed |
| handover_req | input | 1 | Supervisor asks to hand the bus to the test master |
| test_done | input | 1 | Test master reports that it has finished |
| test_active | output | 1 | The test master owns the bus |
| rom_wr_viol | output | 1 | Sticky flag: a ROM write was attempted |
| sup_valid | input | 1 | Supervisor request valid |
| sup_we | input | 1 | Supervisor write (1) or read (0) |
| sup_addr | input | ADDR_W | Supervisor address |
| sup_wdata | input | DATA_W | Supervisor write data |
| sup_ready | output | 1 | Supervisor transfer accepted |
| sup_rdata | output | DATA_W | Supervisor read data |
| tst_valid | input | 1 | Test-master request valid |
| tst_we | input | 1 | Test-master write (1) or read (0) |
| tst_addr | input | ADDR_W | Test-master address |
| tst_wdata | input | DATA_W | Test-master write data |
| tst_ready | output | 1 | Test-master transfer accepted |
| tst_rdata | output | DATA_W | Test-master read data |
| rom_en | output | 1 | ROM read enable |
| rom_addr | output | ADDR_W-1 | ROM word address |
| rom_rdata | input | DATA_W | ROM read data, same cycle |
| ram_en | output | 1 | RAM access enable |
| ram_we | output | 1 | RAM write enable |
| ram_addr | output | ADDR_W-1 | RAM word address |
| ram_wdata | output | DATA_W | RAM write data |
| ram_rdata | input | DATA_W | RAM read data, same cycle |

## Verification
The hardest situation to reach is the test phase with the supervisor still active, because three conditions must line up first: `verify_done` high, a `handover_req` in the supervisor phase, and the idle cycle completed. The stimulus first shows that a request made without verification leaves the test master locked out. It then raises the verification level, pulses the request, and checks the idle cycle before sweeping every ROM and RAM word from the test master. During that phase, supervisor writes are issued against words the test has already written. Reading those words back after the return cycle shows whether any dropped write leaked into memory.

// File: rtl/bosw_pkg.sv
package bosw_pkg;
  typedef enum logic [1:0] {
    OWN_SUP  = 2'd0,
    OWN_HAND = 2'd1,
    OWN_TEST = 2'd2,
    OWN_RET  = 2'd3
  } own_st_e;

  localparam int unsigned N_MST   = 2;
  localparam int unsigned MST_SUP = 0;
  localparam int unsigned MST_TST = 1;
endpackage

// File: rtl/bosw_ctrl.sv
module bosw_ctrl
  import bosw_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    verify_done,
  input  logic    handover_req,
  input  logic    test_done,
  output own_st_e st
);
  own_st_e nxt;

  always_comb begin
    nxt = st;
    unique case (st)
      OWN_SUP:  if (handover_req && verify_done) nxt = OWN_HAND;
      OWN_HAND: nxt = OWN_TEST;
      OWN_TEST: if (test_done) nxt = OWN_RET;
      OWN_RET:  nxt = OWN_SUP;
      default:  nxt = OWN_SUP;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= OWN_SUP;
    else        st <= nxt;
  end
endmodule

// File: rtl/bosw_decode.sv
module bosw_decode #(
  parameter int unsigned ADDR_W = 8
) (
  input  logic              valid,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic              owns,
  output logic              rom_rd,
  output logic              rom_wr,
  output logic              ram_acc
);
  logic hit;
  logic in_ram;

  assign hit     = valid && owns;
  assign in_ram  = addr[ADDR_W-1];
  assign rom_rd  = hit && !in_ram && !we;
  assign rom_wr  = hit && !in_ram && we;
  assign ram_acc = hit && in_ram;
endmodule

// File: rtl/bosw_route.sv
module bosw_route
  import bosw_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 16,
  localparam int unsigned WA_W  = ADDR_W - 1
) (
  input  logic [N_MST-1:0]             owns,
  input  logic [N_MST-1:0]             rom_rd,
  input  logic [N_MST-1:0]             ram_acc,
  input  logic [N_MST-1:0]             we,
  input  logic [N_MST-1:0][ADDR_W-1:0] addr,
  input  logic [N_MST-1:0][DATA_W-1:0] wdata,
  output logic                         rom_en,
  output logic [WA_W-1:0]              rom_addr,
  output logic                         ram_en,
  output logic                         ram_we,
  output logic [WA_W-1:0]              ram_addr,
  output logic [DATA_W-1:0]            ram_wdata
);
  always_comb begin
    rom_en    = 1'b0;
    rom_addr  = '0;
    ram_en    = 1'b0;
    ram_we    = 1'b0;
    ram_addr  = '0;
    ram_wdata = '0;
    for (int i = 0; i < N_MST; i++) begin
      if (owns[i]) begin
        rom_en    = rom_rd[i];
        rom_addr  = addr[i][WA_W-1:0];
        ram_en    = ram_acc[i];
        ram_we    = ram_acc[i] && we[i];
        ram_addr  = addr[i][WA_W-1:0];
        ram_wdata = wdata[i];
      end
    end
  end
endmodule

// File: rtl/bus_owner_switch.sv
module bus_owner_switch
  import bosw_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 16,
  localparam int unsigned WA_W  = ADDR_W - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              verify_done,
  input  logic              handover_req,
  input  logic              test_done,
  output logic              test_active,
  output logic              rom_wr_viol,
  input  logic              sup_valid,
  input  logic              sup_we,
  input  logic [ADDR_W-1:0] sup_addr,
  input  logic [DATA_W-1:0] sup_wdata,
  output logic              sup_ready,
  output logic [DATA_W-1:0] sup_rdata,
  input  logic              tst_valid,
  input  logic              tst_we,
  input  logic [ADDR_W-1:0] tst_addr,
  input  logic [DATA_W-1:0] tst_wdata,
  output logic              tst_ready,
  output logic [DATA_W-1:0] tst_rdata,
  output logic              rom_en,
  output logic [WA_W-1:0]   rom_addr,
  input  logic [DATA_W-1:0] rom_rdata,
  output logic              ram_en,
  output logic              ram_we,
  output logic [WA_W-1:0]   ram_addr,
  output logic [DATA_W-1:0] ram_wdata,
  input  logic [DATA_W-1:0] ram_rdata
);
  own_st_e st;

  logic [N_MST-1:0]             m_valid, m_we, owns;
  logic [N_MST-1:0]             rom_rd, rom_wr, ram_acc;
  logic [N_MST-1:0][ADDR_W-1:0] m_addr;
  logic [N_MST-1:0][DATA_W-1:0] m_wdata, m_rdata;
  logic                         bus_idle;

  assign m_valid = {tst_valid, sup_valid};
  assign m_we    = {tst_we, sup_we};
  assign m_addr  = {tst_addr, sup_addr};
  assign m_wdata = {tst_wdata, sup_wdata};

  bosw_ctrl u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .verify_done  (verify_done),
    .handover_req (handover_req),
    .test_done    (test_done),
    .st           (st)
  );

  assign owns[MST_SUP] = (st == OWN_SUP);
  assign owns[MST_TST] = (st == OWN_TEST);
  assign bus_idle      = (st == OWN_HAND) || (st == OWN_RET);

  for (genvar g = 0; g < N_MST; g++) begin : g_mst
    bosw_decode #(.ADDR_W(ADDR_W)) u_dec (
      .valid   (m_valid[g]),
      .we      (m_we[g]),
      .addr    (m_addr[g]),
      .owns    (owns[g]),
      .rom_rd  (rom_rd[g]),
      .rom_wr  (rom_wr[g]),
      .ram_acc (ram_acc[g])
    );
    always_comb begin
      m_rdata[g] = '0;
      if (rom_rd[g])                 m_rdata[g] = rom_rdata;
      else if (ram_acc[g] && !m_we[g]) m_rdata[g] = ram_rdata;
    end
  end

  bosw_route #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_route (
    .owns      (owns),
    .rom_rd    (rom_rd),
    .ram_acc   (ram_acc),
    .we        (m_we),
    .addr      (m_addr),
    .wdata     (m_wdata),
    .rom_en    (rom_en),
    .rom_addr  (rom_addr),
    .ram_en    (ram_en),
    .ram_we    (ram_we),
    .ram_addr  (ram_addr),
    .ram_wdata (ram_wdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         rom_wr_viol <= 1'b0;
    else if (|rom_wr)   rom_wr_viol <= 1'b1;
  end

  assign test_active = owns[MST_TST];
  assign sup_ready   = !bus_idle;
  assign tst_ready   = !bus_idle;
  assign sup_rdata   = m_rdata[MST_SUP];
  assign tst_rdata   = m_rdata[MST_TST];
endmodule

// File: rtl/bosw_chk.sv
module bosw_chk
  import bosw_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input own_st_e           st,
  input logic              verify_done,
  input logic              rom_wr_viol,
  input logic              rom_en,
  input logic              ram_en,
  input logic              sup_ready,
  input logic              tst_ready,
  input logic [DATA_W-1:0] sup_rdata,
  input logic [DATA_W-1:0] tst_rdata,
  input logic              tst_valid,
  input logic              tst_we,
  input logic [ADDR_W-1:0] tst_addr
);
  AST_NO_EARLY_HANDOVER: assert property (@(posedge clk) disable iff (!rst_n)
    (st == OWN_SUP && !verify_done) |=> (st == OWN_SUP)); // R2
  AST_ONE_IDLE_IN: assert property (@(posedge clk) disable iff (!rst_n)
    (st == OWN_HAND) |=> (st == OWN_TEST)); // R3
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (st == OWN_HAND || st == OWN_RET) |-> (!rom_en && !ram_en && !sup_ready && !tst_ready)); // R4
  AST_SUP_MUTED: assert property (@(posedge clk) disable iff (!rst_n)
    (st == OWN_TEST) |-> (sup_rdata == '0)); // R6
  AST_TST_MUTED: assert property (@(posedge clk) disable iff (!rst_n)
    (st == OWN_SUP) |-> (tst_rdata == '0)); // R6
  AST_ROM_WR_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (st == OWN_TEST && tst_valid && tst_we && !tst_addr[ADDR_W-1]) |=> rom_wr_viol); // R7
  AST_VIOL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    rom_wr_viol |=> rom_wr_viol); // R7
  AST_ONE_IDLE_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    (st == OWN_RET) |=> (st == OWN_SUP)); // R8
endmodule

bind bus_owner_switch bosw_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .st          (st),
  .verify_done (verify_done),
  .rom_wr_viol (rom_wr_viol),
  .rom_en      (rom_en),
  .ram_en      (ram_en),
  .sup_ready   (sup_ready),
  .tst_ready   (tst_ready),
  .sup_rdata   (sup_rdata),
  .tst_rdata   (tst_rdata),
  .tst_valid   (tst_valid),
  .tst_we      (tst_we),
  .tst_addr    (tst_addr)
);

// File: tb/sim_bus_owner_switch.sv
module sim_bus_owner_switch;
  localparam int AW = 8;
  localparam int DW = 16;
  localparam int WN = 1 << (AW - 1);

  logic clk = 0, rst_n = 0;
  logic verify_done = 0, handover_req = 0, test_done = 0;
  logic test_active, rom_wr_viol;
  logic sup_valid = 0, sup_we = 0, tst_valid = 0, tst_we = 0;
  logic [AW-1:0] sup_addr = '0, tst_addr = '0;
  logic [DW-1:0] sup_wdata = '0, tst_wdata = '0;
  logic sup_ready, tst_ready, rom_en, ram_en, ram_we;
  logic [DW-1:0] sup_rdata, tst_rdata, rom_rdata, ram_rdata, ram_wdata;
  logic [AW-2:0] rom_addr, ram_addr;
  logic [DW-1:0] ram [WN];

  int vecs = 0, errs = 0;
  bit done = 0;

  always #2 clk = ~clk;

  function automatic logic [DW-1:0] rom_f(int a);
    return DW'(a * 37 + 5);
  endfunction
  function automatic logic [DW-1:0] pat(int a);
    return DW'(a * 113) ^ 16'hA5A5;
  endfunction

  assign rom_rdata = rom_f(int'(rom_addr));
  assign ram_rdata = ram[ram_addr];
  always_ff @(posedge clk) if (ram_en && ram_we) ram[ram_addr] <= ram_wdata;

  bus_owner_switch #(.ADDR_W(AW), .DATA_W(DW)) u0 (.*);

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s act=%0h exp=%0h", rq, act, exp);
    end
  endtask

  task automatic cyc(input logic sv, input logic sw, input logic [AW-1:0] sa, input logic [DW-1:0] sd,
                     input logic tv, input logic tw, input logic [AW-1:0] ta, input logic [DW-1:0] td);
    @(negedge clk);
    handover_req = 0; test_done = 0;
    sup_valid = sv; sup_we = sw; sup_addr = sa; sup_wdata = sd;
    tst_valid = tv; tst_we = tw; tst_addr = ta; tst_wdata = td;
    #1;
  endtask

  task automatic idle();
    cyc(0, 0, '0, '0, 0, 0, '0, '0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errs++;
      $display("FAIL watchdog act=%0h exp=%0h", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < WN; i++) ram[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    idle();
    chk("R1 test_active", test_active, 0);
    chk("R1 viol", rom_wr_viol, 0);

    // R2: request without verification
    @(negedge clk); handover_req = 1; #1;
    idle(); idle();
    cyc(0, 0, '0, '0, 1, 0, 8'h03, '0);
    chk("R2 test_active", test_active, 0);
    chk("R2 tst_rdata", tst_rdata, 0);
    chk("R6 tst_ready", tst_ready, 1);
    chk("R6 rom_en", rom_en, 0);

    // R10: supervisor access in its phase
    for (int i = 0; i < 16; i++) cyc(1, 1, AW'(WN + i), DW'(16'h1000 + i), 0, 0, '0, '0);
    for (int i = 0; i < 16; i++) begin
      cyc(1, 0, AW'(WN + i), '0, 0, 0, '0, '0);
      chk("R10 ram rd", sup_rdata, DW'(16'h1000 + i));
    end
    cyc(1, 0, 8'h03, '0, 0, 0, '0, '0);
    chk("R10 rom rd", sup_rdata, rom_f(3));
    chk("R10 rom_en", rom_en, 1);

    // R9: test_done in supervisor phase
    @(negedge clk); test_done = 1; #1;
    idle();
    chk("R9 done ignored", test_active, 0);

    // R3/R4: handover
    verify_done = 1;
    @(negedge clk); handover_req = 1; #1;
    cyc(1, 0, 8'h03, '0, 1, 0, 8'h83, '0);
    chk("R4 sup_ready", sup_ready, 0);
    chk("R4 tst_ready", tst_ready, 0);
    chk("R4 rom_en", rom_en, 0);
    chk("R4 ram_en", ram_en, 0);
    chk("R3 idle", test_active, 0);
    idle();
    chk("R3 test_active", test_active, 1);

    // R5: full sweep by test master
    for (int i = 0; i < WN; i++) begin
      cyc(0, 0, '0, '0, 1, 0, AW'(i), '0);
      chk("R5 rom rd", tst_rdata, rom_f(i));
    end
    for (int i = 0; i < WN; i++) cyc(0, 0, '0, '0, 1, 1, AW'(WN + i), pat(i));
    for (int i = 0; i < WN; i++) begin
      cyc(0, 0, '0, '0, 1, 0, AW'(WN + i), '0);
      chk("R5 ram rd", tst_rdata, pat(i));
    end

    // R6: supervisor muted during test
    cyc(1, 1, AW'(WN), 16'hDEAD, 0, 0, '0, '0);
    chk("R6 ram_en", ram_en, 0);
    chk("R6 sup_ready", sup_ready, 1);
    cyc(1, 0, AW'(WN + 1), '0, 0, 0, '0, '0);
    chk("R6 sup_rdata", sup_rdata, 0);
    cyc(0, 0, '0, '0, 1, 0, AW'(WN), '0);
    chk("R6 no leak", tst_rdata, pat(0));

    // R9: handover_req in test phase
    @(negedge clk); handover_req = 1; #1;
    idle(); idle();
    chk("R9 req ignored", test_active, 1);

    // R7: ROM write
    cyc(0, 0, '0, '0, 1, 1, 8'h05, 16'hBEEF);
    chk("R7 rom_en", rom_en, 0);
    chk("R7 viol before", rom_wr_viol, 0);
    idle();
    chk("R7 viol set", rom_wr_viol, 1);
    cyc(0, 0, '0, '0, 1, 0, 8'h05, '0);
    chk("R7 rom intact", tst_rdata, rom_f(5));

    // R8: return
    @(negedge clk); test_done = 1; #1;
    cyc(1, 0, AW'(WN), '0, 1, 0, AW'(WN), '0);
    chk("R8 idle", test_active, 0);
    chk("R4 ret sup_ready", sup_ready, 0);
    chk("R4 ret ram_en", ram_en, 0);
    for (int i = 0; i < WN; i++) begin
      cyc(1, 0, AW'(WN + i), '0, 0, 0, '0, '0);
      chk("R8 results", sup_rdata, pat(i));
    end
    cyc(0, 0, '0, '0, 1, 0, AW'(WN + 2), '0);
    chk("R6 tst after", tst_rdata, 0);
    chk("R7 sticky", rom_wr_viol, 1);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule